// File: doc/BRIEF.md
# Sector DMA Request Controller

This block sits on the device side of a flash disk and paces a host DMA engine that reads data out one fixed-size sector at a time. Software programs a control word that holds a start bit, a request-style bit and the number of sectors to move. The block then drives an active-low request line to show that the next sector is ready. It counts the bytes the host reads and, at the end of each sector, waits for that sector's ECC verdict before it offers the next one.

A failed ECC check stops the transfer at once and raises the interrupt. A clean final sector ends the transfer with a completion interrupt and one leftover request, which the host has to discard. Software can stop a running transfer at the next sector boundary by writing the start bit back to zero. Each interrupt cause is latched in a status flag and masked by its own enable. The interrupt line stays low until software writes the clear bit.

Top module: `sdma_req_ctrl`

## Requirements
- R1: After reset, dma_req_n and irq_n are high, and busy, cause_ecc and cause_done are low.
- R2: A write to address 0 while idle, with data bit 0 (enable) = 1 and a nonzero count in bits [CNT_W+1:2], starts a transfer: busy and the request are asserted in the cycle after the write edge.
- R3: With data bit 1 = 0 (level style), the request stays low until the first byte read of the sector (rd_strobe) and goes high after that edge.
- R4: With data bit 1 = 1 (pulse style), every request, including the leftover one, is low for exactly one cycle.
- R5: A sector ends after SECTOR_BYTES reads. The block then waits for ecc_valid with no request asserted. An ecc_valid that arrives while bytes are still being read is ignored.
- R6: When a sector passes ECC, more sectors remain and the enable is still set, the request is asserted again in the cycle after the ecc_valid edge.
- R7: When a sector fails ECC (ecc_valid with ecc_err = 1), cause_ecc is set, busy drops, no further request follows, and irq_n goes low if address 1 bit 0 (ECC interrupt enable) is set.
- R8: When the last sector passes ECC, cause_done is set, busy drops, and irq_n goes low if address 1 bit 1 (completion interrupt enable) is set. One leftover request is also raised. In level style it is held until the next byte read or the next control write.
- R9: A write to address 0 with bit 0 = 0 during a transfer aborts it. The current sector still completes, and at its clean ECC result the block goes idle with no request and no cause set.
- R10: irq_n stays low until a write to address 2 with bit 0 = 1 clears both causes. A cause whose enable is off still sets its flag but does not drive irq_n.
- R11: A start write with a count of zero is treated as no transfer: busy and the request stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 interrupt enables, 2 clear |
| wr_data | input | CNT_W+2 | Write data |
| rd_strobe | input | 1 | Host read of one byte |
| ecc_valid | input | 1 | ECC verdict for the sector just read |
| ecc_err | input | 1 | Verdict is an error (qualified by ecc_valid) |
| dma_req_n | output | 1 | Active-low DMA request |
| irq_n | output | 1 | Active-low interrupt |
| busy | output | 1 | Transfer in progress |
| cause_ecc | output | 1 | Latched ECC-error cause |
| cause_done | output | 1 | Latched completion cause |

## Verification
A wrong byte count shows up as an ECC verdict that is accepted too early or too late. That is visible on dma_req_n in the cycle after the ecc_valid edge, so the bench pulses ecc_valid one byte before the end of a sector. A wrong remaining-sector count ends the transfer a sector early or late, which shows on busy and cause_done in the cycle after that sector's verdict. Errors in the request style or in the interrupt latch show on dma_req_n or irq_n one cycle after the edge that should have changed them.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARM  = 2'd1,
      ST_XFER = 2'd2,
      ST_WAIT = 2'd3
   } sdma_state_e;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_IE   = 2'd1;
   localparam logic [1:0] ADR_CLR  = 2'd2;

   localparam int BIT_EN    = 0;
   localparam int BIT_PULSE = 1;
   localparam int CNT_LSB   = 2;
   localparam int BIT_IE_ECC  = 0;
   localparam int BIT_IE_DONE = 1;
   localparam int BIT_CLR     = 0;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
   import sdma_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W+1:0] wr_data,
   input  logic             idle,
   input  logic             en_clr,
   input  logic             set_ecc,
   input  logic             set_done,
   output logic             ctrl_wr,
   output logic             start,
   output logic [CNT_W-1:0] wr_cnt,
   output logic             wr_pulse,
   output logic             en_q,
   output logic             cause_ecc,
   output logic             cause_done,
   output logic             irq_n
);
   logic ie_ecc_q, ie_done_q, ie_wr, clr_wr;

   assign ctrl_wr  = wr_en && (wr_addr == ADR_CTRL);
   assign ie_wr    = wr_en && (wr_addr == ADR_IE);
   assign clr_wr   = wr_en && (wr_addr == ADR_CLR) && wr_data[BIT_CLR];
   assign wr_cnt   = wr_data[CNT_LSB +: CNT_W];
   assign wr_pulse = wr_data[BIT_PULSE];
   assign start    = ctrl_wr && idle && wr_data[BIT_EN] && (wr_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (en_clr) begin
         en_q <= 1'b0;
      end else if (ctrl_wr) begin
         en_q <= idle ? start : (en_q && wr_data[BIT_EN]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_ecc_q  <= 1'b0;
         ie_done_q <= 1'b0;
      end else if (ie_wr) begin
         ie_ecc_q  <= wr_data[BIT_IE_ECC];
         ie_done_q <= wr_data[BIT_IE_DONE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_ecc  <= 1'b0;
         cause_done <= 1'b0;
      end else begin
         if (set_ecc)     cause_ecc <= 1'b1;
         else if (clr_wr) cause_ecc <= 1'b0;
         if (set_done)    cause_done <= 1'b1;
         else if (clr_wr) cause_done <= 1'b0;
      end
   end

   assign irq_n = !((cause_ecc && ie_ecc_q) || (cause_done && ie_done_q));

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!irq_n && !wr_en) |=> !irq_n); // R10
   AST_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_wr && idle && wr_cnt == '0) |=> !en_q); // R11
endmodule

// File: rtl/sdma_byte_ctr.sv
module sdma_byte_ctr #(
   parameter int SECTOR_BYTES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic count_en,
   output logic last
);
   localparam int  BC_W = (SECTOR_BYTES > 2) ? $clog2(SECTOR_BYTES) : 1;
   localparam bit  POW2 = ((SECTOR_BYTES & (SECTOR_BYTES - 1)) == 0);
   localparam logic [BC_W-1:0] TOP = BC_W'(SECTOR_BYTES - 1);

   logic [BC_W-1:0] cnt_q;

   initial begin : chk_size
      assert (SECTOR_BYTES >= 2) else $fatal(1, "SECTOR_BYTES must be at least 2");
   end

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (clear)    cnt_q <= '0;
            else if (count_en) cnt_q <= cnt_q + 1'b1;
         end
         assign last = count_en && (&cnt_q);
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             cnt_q <= '0;
            else if (clear || (count_en && cnt_q == TOP)) cnt_q <= '0;
            else if (count_en)                      cnt_q <= cnt_q + 1'b1;
         end
         assign last = count_en && (cnt_q == TOP);
      end
   endgenerate
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
   import sdma_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic             wr_pulse,
   input  logic             ctrl_wr,
   input  logic             en_q,
   input  logic             rd_strobe,
   input  logic             ecc_valid,
   input  logic             ecc_err,
   input  logic             sector_last,
   output logic             byte_en,
   output logic             en_clr,
   output logic             set_ecc,
   output logic             set_done,
   output logic             busy,
   output logic             dma_req_n
);
   sdma_state_e      st_q, st_d;
   logic [CNT_W-1:0] left_q;
   logic             pulse_q, arm_first_q, stray_q, go_arm, dec;

   assign byte_en = rd_strobe && (st_q == ST_ARM || st_q == ST_XFER);
   assign busy    = (st_q != ST_IDLE);

   always_comb begin
      st_d     = st_q;
      go_arm   = 1'b0;
      dec      = 1'b0;
      en_clr   = 1'b0;
      set_ecc  = 1'b0;
      set_done = 1'b0;
      case (st_q)
         ST_IDLE: if (start) begin
            st_d   = ST_ARM;
            go_arm = 1'b1;
         end
         ST_ARM: begin
            if (!en_q)        st_d = ST_IDLE;
            else if (byte_en) st_d = sector_last ? ST_WAIT : ST_XFER;
         end
         ST_XFER: if (sector_last) st_d = ST_WAIT;
         ST_WAIT: if (ecc_valid) begin
            if (ecc_err) begin
               st_d    = ST_IDLE;
               en_clr  = 1'b1;
               set_ecc = 1'b1;
            end else if (left_q == CNT_W'(1)) begin
               st_d     = ST_IDLE;
               en_clr   = 1'b1;
               set_done = 1'b1;
            end else if (en_q) begin
               st_d   = ST_ARM;
               go_arm = 1'b1;
               dec    = 1'b1;
            end else begin
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         left_q      <= '0;
         pulse_q     <= 1'b0;
         arm_first_q <= 1'b0;
         stray_q     <= 1'b0;
      end else begin
         st_q        <= st_d;
         arm_first_q <= go_arm;
         if (start) begin
            left_q  <= wr_cnt;
            pulse_q <= wr_pulse;
         end else if (dec) begin
            left_q <= left_q - 1'b1;
         end
         if (set_done)                              stray_q <= 1'b1;
         else if (pulse_q || rd_strobe || ctrl_wr) stray_q <= 1'b0;
      end
   end

   assign dma_req_n = !(((st_q == ST_ARM) && (!pulse_q || arm_first_q)) || stray_q);

   AST_WAIT_NOREQ: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_WAIT) |-> dma_req_n); // R5
   AST_ECC_HALT: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_WAIT && ecc_valid && ecc_err) |=> (dma_req_n && !busy)); // R7
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n) (pulse_q && !dma_req_n && !ctrl_wr) |=> dma_req_n); // R4
   AST_NEXT_ARM: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_WAIT && ecc_valid && !ecc_err && en_q && left_q != CNT_W'(1)) |=> !dma_req_n); // R6
endmodule

// File: rtl/sdma_req_ctrl.sv
module sdma_req_ctrl
   import sdma_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int CNT_W        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W+1:0] wr_data,
   input  logic             rd_strobe,
   input  logic             ecc_valid,
   input  logic             ecc_err,
   output logic             dma_req_n,
   output logic             irq_n,
   output logic             busy,
   output logic             cause_ecc,
   output logic             cause_done
);
   logic             ctrl_wr, start, wr_pulse, en_q, en_clr, set_ecc, set_done;
   logic             byte_en, sector_last;
   logic [CNT_W-1:0] wr_cnt;

   initial begin : chk_cnt
      assert (CNT_W >= 1 && CNT_W <= 16) else $fatal(1, "CNT_W out of range");
   end

   sdma_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .idle(!busy), .en_clr(en_clr), .set_ecc(set_ecc), .set_done(set_done),
      .ctrl_wr(ctrl_wr), .start(start), .wr_cnt(wr_cnt), .wr_pulse(wr_pulse),
      .en_q(en_q), .cause_ecc(cause_ecc), .cause_done(cause_done), .irq_n(irq_n)
   );

   sdma_byte_ctr #(.SECTOR_BYTES(SECTOR_BYTES)) u_bytes (
      .clk(clk), .rst_n(rst_n), .clear(start), .count_en(byte_en), .last(sector_last)
   );

   sdma_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .wr_cnt(wr_cnt), .wr_pulse(wr_pulse),
      .ctrl_wr(ctrl_wr), .en_q(en_q), .rd_strobe(rd_strobe), .ecc_valid(ecc_valid),
      .ecc_err(ecc_err), .sector_last(sector_last), .byte_en(byte_en), .en_clr(en_clr),
      .set_ecc(set_ecc), .set_done(set_done), .busy(busy), .dma_req_n(dma_req_n)
   );
endmodule

// File: tb/sim_sdma_req_ctrl.sv
`timescale 1ns/1ps
module sim_sdma_req_ctrl;
   localparam int SB    = 512;
   localparam int CNT_W = 8;

   typedef struct {
      bit    req_n;
      bit    irq_n;
      bit    busy;
      bit    ce;
      bit    cd;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [CNT_W+1:0] wr_data = '0;
   logic rd_strobe = 1'b0, ecc_valid = 1'b0, ecc_err = 1'b0;
   logic dma_req_n, irq_n, busy, cause_ecc, cause_done;

   exp_t q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   finished = 1'b0;

   always #2 clk = ~clk;

   sdma_req_ctrl #(.SECTOR_BYTES(SB), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_strobe(rd_strobe), .ecc_valid(ecc_valid), .ecc_err(ecc_err),
      .dma_req_n(dma_req_n), .irq_n(irq_n), .busy(busy),
      .cause_ecc(cause_ecc), .cause_done(cause_done)
   );

   // monitor: compares every queued expectation at the falling edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_vec++;
         if ({dma_req_n, irq_n, busy, cause_ecc, cause_done} !== {e.req_n, e.irq_n, e.busy, e.ce, e.cd}) begin
            n_bad++;
            $display("FAIL %s: req_n/irq_n/busy/ce/cd actual %b%b%b%b%b expected %b%b%b%b%b", e.tag,
                     dma_req_n, irq_n, busy, cause_ecc, cause_done, e.req_n, e.irq_n, e.busy, e.ce, e.cd);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(bit r, bit i, bit b, bit ce, bit cd, string tag);
      exp_t e;
      e.req_n = r; e.irq_n = i; e.busy = b; e.ce = ce; e.cd = cd; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic wr(logic [1:0] a, logic [CNT_W+1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic ctrl(int cnt, bit pulse, bit en);
      wr(2'd0, {CNT_W'(cnt), pulse, en});
   endtask

   task automatic reads(int n);
      rd_strobe = 1'b1;
      repeat (n) tick();
      rd_strobe = 1'b0;
   endtask

   task automatic ecc(bit err);
      ecc_valid = 1'b1; ecc_err = err;
      tick();
      ecc_valid = 1'b0; ecc_err = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      expect_out(1, 1, 0, 0, 0, "R1 reset state");

      // level style, two sectors, both interrupts enabled
      wr(2'd1, 10'd3);
      ctrl(2, 0, 1);
      expect_out(0, 1, 1, 0, 0, "R2 start asserts request");
      tick();
      expect_out(0, 1, 1, 0, 0, "R3 level request held");
      reads(1);
      expect_out(1, 1, 1, 0, 0, "R3 request released by first read");
      reads(SB - 2);
      ecc(0);
      expect_out(1, 1, 1, 0, 0, "R5 early ecc_valid ignored");
      reads(1);
      expect_out(1, 1, 1, 0, 0, "R5 no request while waiting for ECC");
      ecc(0);
      expect_out(0, 1, 1, 0, 0, "R6 next sector request");
      reads(SB);
      expect_out(1, 1, 1, 0, 0, "R5 second sector read");
      ecc(0);
      expect_out(0, 0, 0, 0, 1, "R8 done irq and leftover request");
      tick();
      expect_out(0, 0, 0, 0, 1, "R8 leftover request held in level style");
      reads(1);
      expect_out(1, 0, 0, 0, 1, "R8 leftover request dropped by read");
      tick();
      expect_out(1, 0, 0, 0, 1, "R10 irq holds without clear");
      wr(2'd2, 10'd1);
      expect_out(1, 1, 0, 0, 0, "R10 clear write releases irq");

      // pulse style, ECC error on second of three sectors
      ctrl(3, 1, 1);
      expect_out(0, 1, 1, 0, 0, "R4 pulse request low");
      tick();
      expect_out(1, 1, 1, 0, 0, "R4 pulse request one cycle");
      reads(SB);
      ecc(0);
      expect_out(0, 1, 1, 0, 0, "R6 pulse re-arm");
      tick();
      expect_out(1, 1, 1, 0, 0, "R4 re-arm pulse one cycle");
      reads(SB);
      ecc(1);
      expect_out(1, 0, 0, 1, 0, "R7 ECC error halts with irq");
      tick();
      expect_out(1, 0, 0, 1, 0, "R7 no request after ECC halt");
      wr(2'd2, 10'd1);
      expect_out(1, 1, 0, 0, 0, "R10 clear after ECC");

      // abort at sector boundary
      ctrl(3, 0, 1);
      expect_out(0, 1, 1, 0, 0, "R2 start for abort test");
      reads(100);
      ctrl(7, 1, 0);
      expect_out(1, 1, 1, 0, 0, "R9 abort keeps current sector");
      reads(SB - 100);
      expect_out(1, 1, 1, 0, 0, "R9 sector finishes after abort");
      ecc(0);
      expect_out(1, 1, 0, 0, 0, "R9 aborted at boundary");
      tick();
      expect_out(1, 1, 0, 0, 0, "R9 no request after abort");

      // zero count
      ctrl(0, 0, 1);
      expect_out(1, 1, 0, 0, 0, "R11 zero count no transfer");
      tick();
      expect_out(1, 1, 0, 0, 0, "R11 still idle");

      // masked completion, pulse leftover
      wr(2'd1, 10'd0);
      ctrl(1, 1, 1);
      expect_out(0, 1, 1, 0, 0, "R4 single sector pulse");
      tick();
      expect_out(1, 1, 1, 0, 0, "R4 single pulse ends");
      reads(SB);
      ecc(0);
      expect_out(0, 1, 0, 0, 1, "R10 masked done, R8 leftover pulse");
      tick();
      expect_out(1, 1, 0, 0, 1, "R4 leftover pulse one cycle");
      wr(2'd1, 10'd2);
      expect_out(1, 0, 0, 0, 1, "R10 enabling shows pending cause");
      wr(2'd2, 10'd1);
      expect_out(1, 1, 0, 0, 0, "R10 final clear");

      tick();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule